// File: doc/BRIEF.md
# Phase-Sweep Edge Propagation Search

This controller measures how far a launched signal edge travels through a row of capture flip-flops as the launch-to-capture interval changes. It owns a fine phase-shift setting, `phase_req`. For each setting it runs one test on an external launch/capture engine, using a start/ready pair of pins. When the test ends, it inspects the captured row. From that row it decides whether the edge has reached the chosen flip-flop, whether to move on to the next setting, or whether to give up.

A caller starts a search with a valid/ready handshake on `sweep_valid`/`sweep_ready`. The direction of the search (`search_down`) and the target index (`target_idx`) are sampled at that moment. There is no back-pressure on the result. When `sweep_ready` rises again, `phase_req` and `found` hold the outcome, and they stay stable until the next accepted request. A forward search climbs from the zero-phase value. A backward search descends from the longest legal setting.

Top module: `edge_sweep_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, `sweep_ready` is 1, `phase_req` equals the zero-phase value (0), `found` is 0 and `lc_start` is 0.
- R2: A request is accepted on a cycle where `sweep_valid` and `sweep_ready` are both 1. `sweep_ready` is 0 from the next cycle until the result is presented.
- R3: `lc_start` is a one-cycle pulse, issued only while `lc_ready` is 1. Exactly one test is issued per phase setting visited, and the next test waits until the engine has returned `lc_ready` high.
- R4: A transition is a pair of adjacent row bits `row_bits[i] != row_bits[i-1]`, for i from 1 to 263. Its position is i.
- R5: Forward search (`search_down`=0) starts at phase 0 and adds 1 per test. It stops with `found`=1 at the first test whose row holds exactly one transition with position greater than the target.
- R6: Backward search (`search_down`=1) starts at phase 559 and subtracts 1 per test. It stops with `found`=1 at the first test whose row holds exactly one transition with position less than or equal to the target.
- R7: A row with no transition never stops the search. The sweep moves to the next setting.
- R8: A row with two or more transitions ends the search at once, with `found`=0. `phase_req` keeps the setting of that test.
- R9: If the last legal setting (559 forward, 0 backward) is tested without a stop, the search ends with `found`=0 and `phase_req` at that setting. `phase_req` never leaves 0..559.
- R10: Changes to `search_down` or `target_idx` after acceptance have no effect on the running search.
- R11: `sweep_valid` while a search runs is ignored and does not restart it.
- R12: While idle, `phase_req` and `found` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sweep_valid | input | 1 | Search request |
| sweep_ready | output | 1 | Idle, and result valid |
| search_down | input | 1 | 1 = backward search, 0 = forward search |
| target_idx | input | 9 | Absolute index of the target flip-flop in the row |
| lc_start | output | 1 | One-cycle start pulse to the test engine |
| lc_ready | input | 1 | Test engine idle; the row is valid when it returns high |
| row_bits | input | 264 | Captured flip-flop row |
| phase_req | output | 10 | Current phase setting; the measured value at the end |
| found | output | 1 | Stop condition met |

## Verification
`sweep_ready` must be low on the first cycle after acceptance. The bench checks this on the falling edge right after the accepting clock edge. Each result becomes due on the cycle when `sweep_ready` rises again. That moment depends on how many tests run and on the engine latency: about seven cycles per test, with ISSUE, engine wait and DECIDE. The monitor therefore keys its comparison on that rising edge rather than on a fixed cycle count. At the same point it compares the number of `lc_start` pulses counted since the previous result against the number of settings the requirements predict.

// File: rtl/edge_sweep_pkg.sv
package edge_sweep_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_WAIT   = 2'd2,
    ST_DECIDE = 2'd3
  } sweep_state_t;

  typedef enum logic [1:0] {
    TR_NONE = 2'd0,
    TR_ONE  = 2'd1,
    TR_MANY = 2'd2
  } trans_cls_t;

endpackage

// File: rtl/edge_scan.sv
module edge_scan
  import edge_sweep_pkg::*;
#(
  parameter int ROW_W = 264,
  parameter int POS_W = $clog2(ROW_W)
) (
  input  logic [ROW_W-1:0] row,
  output trans_cls_t       cls,
  output logic [POS_W-1:0] pos
);

  logic [ROW_W-1:1] diff;

  // one comparator per neighbouring pair
  for (genvar g = 1; g < ROW_W; g++) begin : g_pair
    assign diff[g] = row[g] ^ row[g-1];
  end

  logic [1:0] hits;

  always_comb begin
    hits = 2'd0;
    pos  = '0;
    for (int i = 1; i < ROW_W; i++) begin
      if (diff[i]) begin
        pos = POS_W'(i);
        if (hits != 2'd2) hits = hits + 2'd1;
      end
    end
  end

  always_comb begin
    case (hits)
      2'd0:    cls = TR_NONE;
      2'd1:    cls = TR_ONE;
      default: cls = TR_MANY;
    endcase
  end

endmodule

// File: rtl/phase_stepper.sv
module phase_stepper #(
  parameter int PHASE_W    = 10,
  parameter int PHASE_ZERO = 0,
  parameter int PHASE_SPAN = 560
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               load_down,
  input  logic               step,
  output logic [PHASE_W-1:0] phase,
  output logic               at_end
);

  localparam logic [PHASE_W-1:0] FIRST = PHASE_W'(PHASE_ZERO);
  localparam logic [PHASE_W-1:0] LAST  = PHASE_W'(PHASE_ZERO + PHASE_SPAN - 1);

  logic down_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= FIRST;
      down_q <= 1'b0;
    end else if (load) begin
      phase  <= load_down ? LAST : FIRST;
      down_q <= load_down;
    end else if (step) begin
      phase  <= down_q ? phase - 1'b1 : phase + 1'b1;
    end
  end

  assign at_end = down_q ? (phase == FIRST) : (phase == LAST);

  // R9
  phase_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase >= FIRST) && (phase <= LAST));

  // R5 R6
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (phase == ($past(down_q) ? $past(phase) - 1'b1 : $past(phase) + 1'b1)));

endmodule

// File: rtl/edge_sweep_ctrl.sv
module edge_sweep_ctrl
  import edge_sweep_pkg::*;
#(
  parameter int PHASE_W    = 10,
  parameter int PHASE_ZERO = 0,
  parameter int PHASE_SPAN = 560,
  parameter int ROW_W      = 264,
  parameter int IDX_W      = $clog2(ROW_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sweep_valid,
  output logic               sweep_ready,
  input  logic               search_down,
  input  logic [IDX_W-1:0]   target_idx,
  output logic               lc_start,
  input  logic               lc_ready,
  input  logic [ROW_W-1:0]   row_bits,
  output logic [PHASE_W-1:0] phase_req,
  output logic               found
);

  sweep_state_t     state_q;
  logic             ready_q, found_q, down_q;
  logic [IDX_W-1:0] tgt_q, pos_q;
  trans_cls_t       cls_q;

  trans_cls_t       cls_w;
  logic [IDX_W-1:0] pos_w;
  logic             accept, step, at_end, hit;

  edge_scan #(.ROW_W(ROW_W), .POS_W(IDX_W)) u_scan (
    .row (row_bits),
    .cls (cls_w),
    .pos (pos_w)
  );

  assign accept = sweep_valid && ready_q && (state_q == ST_IDLE);

  // stop test on the registered row summary
  assign hit = (cls_q == TR_ONE) &&
               (down_q ? (pos_q <= tgt_q) : (pos_q > tgt_q));

  assign step = (state_q == ST_DECIDE) && (cls_q != TR_MANY) && !hit && !at_end;

  phase_stepper #(
    .PHASE_W(PHASE_W), .PHASE_ZERO(PHASE_ZERO), .PHASE_SPAN(PHASE_SPAN)
  ) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_down (search_down),
    .step      (step),
    .phase     (phase_req),
    .at_end    (at_end)
  );

  assign lc_start = (state_q == ST_ISSUE) && lc_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b1;
      found_q <= 1'b0;
      down_q  <= 1'b0;
      tgt_q   <= '0;
      pos_q   <= '0;
      cls_q   <= TR_NONE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            ready_q <= 1'b0;
            found_q <= 1'b0;
            down_q  <= search_down;
            tgt_q   <= target_idx;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (lc_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (lc_ready) begin
            cls_q   <= cls_w;
            pos_q   <= pos_w;
            state_q <= ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          if (cls_q == TR_MANY || hit || at_end) begin
            found_q <= (cls_q != TR_MANY) && hit;
            ready_q <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_ISSUE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sweep_ready = ready_q;
  assign found       = found_q;

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_valid && sweep_ready) |=> !sweep_ready);

  // R3
  single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lc_start |=> !lc_start);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_ready && $past(sweep_ready)) |-> ($stable(phase_req) && $stable(found)));

  // R3
  no_start_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sweep_ready |-> !(lc_start && $past(lc_start)));

endmodule

// File: tb/edge_sweep_ctrl_bench.sv
module edge_sweep_ctrl_bench;

  localparam int ROW_W = 264;
  localparam int PW    = 10;
  localparam int IW    = 9;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sweep_valid = 1'b0;
  logic            sweep_ready;
  logic            search_down = 1'b0;
  logic [IW-1:0]   target_idx = '0;
  logic            lc_start;
  logic            lc_ready;
  logic [ROW_W-1:0] row_bits;
  logic [PW-1:0]   phase_req;
  logic            found;

  always #2 clk = ~clk;

  edge_sweep_ctrl u_edge_sweep_ctrl (
    .clk(clk), .rst_n(rst_n), .sweep_valid(sweep_valid), .sweep_ready(sweep_ready),
    .search_down(search_down), .target_idx(target_idx), .lc_start(lc_start),
    .lc_ready(lc_ready), .row_bits(row_bits), .phase_req(phase_req), .found(found)
  );

  int vectors = 0;
  int errors  = 0;
  int glitch_ph = -1;

  // engine model: edge boundary advances one bit every four phase steps
  function automatic logic [ROW_W-1:0] mk_row(int ph, int gph);
    logic [ROW_W-1:0] r;
    int b;
    r = '0;
    b = ph / 4;
    if (b > ROW_W - 1) b = ROW_W - 1;
    for (int i = 0; i < b; i++) r[i] = 1'b1;
    if (ph == gph) r[ROW_W-1] = 1'b1;
    return r;
  endfunction

  int eng_cnt;
  int eng_ph;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_ready <= 1'b1;
      row_bits <= '0;
      eng_cnt  <= 0;
      eng_ph   <= 0;
    end else if (lc_start && lc_ready) begin
      lc_ready <= 1'b0;
      eng_cnt  <= 3;
      eng_ph   <= int'(phase_req);
    end else if (!lc_ready) begin
      if (eng_cnt == 0) begin
        lc_ready <= 1'b1;
        row_bits <= mk_row(eng_ph, glitch_ph);
      end else begin
        eng_cnt <= eng_cnt - 1;
      end
    end
  end

  typedef struct {
    int ph;
    bit fnd;
    int n;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  task automatic check(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compare on each return of sweep_ready
  bit prev_rdy = 1'b1;
  int starts = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (lc_start) begin
        starts++;
        if (!lc_ready) check(1'b0, "R3 start while engine busy", 1, 0);
      end
      if (sweep_ready && !prev_rdy) begin
        exp_t e;
        string t;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected result", 1, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(int'(phase_req) == e.ph, {t, " phase"}, int'(phase_req), e.ph);
          check(found == e.fnd, {t, " found"}, int'(found), int'(e.fnd));
          check(starts == e.n, "R3 tests issued", starts, e.n);
        end
        starts = 0;
      end
      prev_rdy = sweep_ready;
    end
  end

  // driver: push expectation, issue request, wait for the monitor
  task automatic run(bit dn, int tgt, int gph, int eph, bit efnd, int en,
                     string tag, bit disturb);
    exp_t e;
    e.ph = eph; e.fnd = efnd; e.n = en;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    glitch_ph   = gph;
    search_down = dn;
    target_idx  = IW'(tgt);
    sweep_valid = 1'b1;
    @(negedge clk);
    sweep_valid = 1'b0;
    check(sweep_ready == 1'b0, "R2 ready low after accept", int'(sweep_ready), 0);
    if (disturb) begin
      // R10 R11: flip mode and target, pulse a second request mid-run
      repeat (5) @(negedge clk);
      search_down = ~dn;
      target_idx  = '0;
      sweep_valid = 1'b1;
      @(negedge clk);
      sweep_valid = 1'b0;
      check(sweep_ready == 1'b0, "R11 request ignored while busy", int'(sweep_ready), 0);
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check(sweep_ready == 1'b1, "R1 ready", int'(sweep_ready), 1);
    check(phase_req == '0, "R1 phase", int'(phase_req), 0);
    check(found == 1'b0, "R1 found", int'(found), 0);
    check(lc_start == 1'b0, "R1 start", int'(lc_start), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R4: forward, target 10 -> first position 11 at phase 44
    run(1'b0, 10, -1, 44, 1'b1, 45, "R5 fwd t10", 1'b0);
    // R5 boundary: target 0, R7 zero transitions at phases 0..3
    run(1'b0, 0, -1, 4, 1'b1, 5, "R7 fwd t0", 1'b0);
    // R6: backward, target 10 -> position 10 first at phase 43
    run(1'b1, 10, -1, 43, 1'b1, 517, "R6 bwd t10", 1'b0);
    // R6: backward stops on very first test
    run(1'b1, 200, -1, 559, 1'b1, 1, "R6 bwd t200", 1'b0);
    // R9: forward runs out of range
    run(1'b0, 200, -1, 559, 1'b0, 560, "R9 fwd exhaust", 1'b0);
    // R9 R7: backward runs out, last rows have no transition
    run(1'b1, 0, -1, 0, 1'b0, 560, "R9 bwd exhaust", 1'b0);
    // R8: two transitions at phase 20 abort
    run(1'b0, 50, 20, 20, 1'b0, 21, "R8 abort", 1'b0);
    // R10 R11: forward target 3 -> phase 16 despite disturbance
    run(1'b0, 3, -1, 16, 1'b1, 17, "R10 latched mode", 1'b1);

    // R12: idle outputs hold
    repeat (10) @(negedge clk);
    check(phase_req == PW'(16), "R12 phase held", int'(phase_req), 16);
    check(found == 1'b1, "R12 found held", int'(found), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 no result actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule